// File: doc/BRIEF.md
# Register-Mapped GCD Peripheral

This block is a slave peripheral on a simple memory-mapped register bus. It holds an iterative greatest-common-divisor engine that works by repeated subtraction. Software stores the first operand in a write-only register and then writes the second operand. That second write is the launch: it offers both operands to the engine in the same bus access. Software learns the engine's progress by polling a two-bit status word. It collects the answer by reading a result register, and that read consumes the result.

Requests arrive on a valid/ready channel. A request is accepted in any cycle where `req_valid` and `req_ready` are both high. Only one kind of request is back-pressured: a write to the second-operand register while the engine cannot take new operands. That write is held with `req_ready` low until the engine accepts it. Every other request is accepted in the cycle it is presented.

Each accepted read returns its data one cycle later, marked by `rsp_valid`. This response channel has no back-pressure. The engine hands each finished result to a one-entry holding slot. While software has not yet read one result, the engine can start and finish the next computation. A plain `engine_busy` output is high while a subtraction run is in progress.

Top module: `gcd_mmio_periph`

## Requirements
- R1: After reset, `engine_busy` is low, a status read returns 0x1 and a result read returns 0.
- R2: An access decodes as a hit only when `req_addr[15:4]` equals `BASE_ADDR[15:4]`; the default base is 0x2000. Within the window, `req_addr[3:2]` selects the register: 0 is status, 1 is the first operand, 2 is the second operand (the launch), and 3 is the result. An access outside the window is accepted in its own cycle and changes nothing, and a read outside the window returns 0.
- R3: A status read returns the engine's input-ready in bit 0 and "result waiting in the slot" in bit 1. All bits above bit 1 read as 0.
- R4: A write to offset 0x8 starts a computation on the first-operand register and the low `OP_W` bits of the written data. The result equals the greatest common divisor of the two operands, with gcd(0,n)=n, gcd(n,0)=n and gcd(0,0)=0.
- R5: `engine_busy` rises in the cycle after the launching write is accepted. It stays high for k+1 cycles, where k is the number of subtraction steps. For example, operands 12 and 8 keep it high for 4 cycles.
- R6: A write to offset 0x8 while the engine is not ready is held with `req_ready` low until the engine accepts it. No other request is ever held.
- R7: A result read while a result is waiting returns that result and clears status bit 1. A result read while nothing is waiting returns the last result delivered and has no effect on the slot.
- R8: `rsp_valid` pulses one cycle after each accepted read, with the read data on `rsp_data`. Writes produce no response. The operand registers read as 0. Writes to the status and result offsets have no effect.
- R9: A finished result can wait in the slot while the engine accepts and runs the next computation. Results are read back in the order they were computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W (16) | Byte address |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after acceptance) |
| rsp_data | output | DATA_W (32) | Read data |
| engine_busy | output | 1 | Subtraction run in progress |

## Verification
Read data is due at the first clock edge after the read is accepted. `engine_busy` follows the accepted launch by one edge. A finished result appears in status bit 1 two edges after the last subtraction: one edge for the engine to detect the zero operand, and one edge for the hand-off to the slot. The bench keeps a behavioural model that steps on every rising edge using the request driven in that cycle. At each falling edge it compares `engine_busy`, `req_ready`, `rsp_valid` and `rsp_data` against that model, so every due cycle is checked exactly where it falls. The bench also makes directed checks of results against a remainder-based divisor computation, of busy durations, and of the stall count on a launch made during a run.

// File: rtl/gcd_mmio_pkg.sv
package gcd_mmio_pkg;
  // word index in req_addr[3:2]
  localparam logic [1:0] WORD_STATUS = 2'd0;
  localparam logic [1:0] WORD_OPA    = 2'd1;
  localparam logic [1:0] WORD_OPB    = 2'd2;
  localparam logic [1:0] WORD_RESULT = 2'd3;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_t;
endpackage

// File: rtl/gcd_sub_engine.sv
module gcd_sub_engine
  import gcd_mmio_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_a,
  input  logic [OP_W-1:0] in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OP_W-1:0] out_val,
  output logic            busy
);
  eng_state_t      state_q;
  logic [OP_W-1:0] a_q, b_q, res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: if (in_valid) begin
          a_q     <= in_a;
          b_q     <= in_b;
          state_q <= ENG_RUN;
        end
        ENG_RUN: begin
          if (a_q == '0) begin
            res_q   <= b_q;
            state_q <= ENG_DONE;
          end else if (b_q == '0) begin
            res_q   <= a_q;
            state_q <= ENG_DONE;
          end else if (a_q >= b_q) begin
            a_q <= a_q - b_q;
          end else begin
            b_q <= b_q - a_q;
          end
        end
        ENG_DONE: if (out_ready) state_q <= ENG_IDLE;
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ENG_IDLE);
  assign out_valid = (state_q == ENG_DONE);
  assign busy      = (state_q == ENG_RUN);
  assign out_val   = res_q;
endmodule

// File: rtl/gcd_result_slot.sv
module gcd_result_slot #(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_valid,
  output logic            fill_ready,
  input  logic [OP_W-1:0] fill_data,
  input  logic            drain,
  output logic            full,
  output logic [OP_W-1:0] held
);
  logic            full_q;
  logic [OP_W-1:0] held_q;

  assign fill_ready = !full_q || drain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      held_q <= '0;
    end else if (fill_valid && fill_ready) begin
      full_q <= 1'b1;
      held_q <= fill_data;
    end else if (drain) begin
      full_q <= 1'b0;
    end
  end

  assign full = full_q;
  assign held = held_q;
endmodule

// File: rtl/gcd_bus_decode.sv
module gcd_bus_decode
  import gcd_mmio_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              OP_W      = 16,
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              eng_in_valid,
  input  logic              eng_in_ready,
  output logic [OP_W-1:0]   eng_a,
  output logic [OP_W-1:0]   eng_b,
  input  logic              slot_full,
  input  logic [OP_W-1:0]   slot_held,
  output logic              slot_drain
);
  localparam int PAD_W = DATA_W - OP_W;

  logic              hit, opb_wr, accept, rd_acc;
  logic [1:0]        word;
  logic [OP_W-1:0]   opa_q;
  logic [DATA_W-1:0] result_ext, rd_mux, rsp_data_q;
  logic              rsp_valid_q;

  assign hit    = (req_addr[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]);
  assign word   = req_addr[3:2];
  assign opb_wr = req_valid && req_write && hit && (word == WORD_OPB);

  assign req_ready    = !opb_wr || eng_in_ready;
  assign accept       = req_valid && req_ready;
  assign rd_acc       = accept && !req_write;
  assign eng_in_valid = opb_wr;
  assign eng_a        = opa_q;
  assign eng_b        = req_wdata[OP_W-1:0];
  assign slot_drain   = rd_acc && hit && (word == WORD_RESULT) && slot_full;

  generate
    if (PAD_W > 0) begin : g_pad
      assign result_ext = {{PAD_W{1'b0}}, slot_held};
    end else begin : g_nopad
      assign result_ext = slot_held;
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (word)
        WORD_STATUS: rd_mux = {{(DATA_W-2){1'b0}}, slot_full, eng_in_ready};
        WORD_RESULT: rd_mux = result_ext;
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (accept && req_write && hit && (word == WORD_OPA))
        opa_q <= req_wdata[OP_W-1:0];
      rsp_valid_q <= rd_acc;
      if (rd_acc) rsp_data_q <= rd_mux;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/gcd_mmio_periph.sv
module gcd_mmio_periph #(
  parameter int                DATA_W    = 32,
  parameter int                OP_W      = 16,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              engine_busy
);
  logic            eng_in_valid, eng_in_ready, eng_out_valid, slot_ready;
  logic [OP_W-1:0] eng_a, eng_b, eng_res, slot_held;
  logic            slot_full, slot_drain;

  gcd_bus_decode #(
    .DATA_W(DATA_W), .OP_W(OP_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .eng_in_valid(eng_in_valid), .eng_in_ready(eng_in_ready),
    .eng_a(eng_a), .eng_b(eng_b),
    .slot_full(slot_full), .slot_held(slot_held), .slot_drain(slot_drain)
  );

  gcd_sub_engine #(.OP_W(OP_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .in_valid(eng_in_valid), .in_ready(eng_in_ready),
    .in_a(eng_a), .in_b(eng_b),
    .out_valid(eng_out_valid), .out_ready(slot_ready), .out_val(eng_res),
    .busy(engine_busy)
  );

  gcd_result_slot #(.OP_W(OP_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(eng_out_valid), .fill_ready(slot_ready), .fill_data(eng_res),
    .drain(slot_drain), .full(slot_full), .held(slot_held)
  );
endmodule

// File: rtl/gcd_mmio_chk.sv
module gcd_mmio_chk #(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              engine_busy
);
  logic in_win, launch, rd_acc, status_rd;
  assign in_win    = (req_addr[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]);
  assign launch    = req_valid && req_write && in_win && (req_addr[3:2] == 2'd2);
  assign rd_acc    = req_valid && req_ready && !req_write;
  assign status_rd = rd_acc && in_win && (req_addr[3:2] == 2'd0);

  // R6
  launch_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && engine_busy) |-> !req_ready);

  // R6
  only_launch_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> launch);

  // R8
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_acc));

  // R5
  busy_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(engine_busy) |-> $past(launch && req_ready));

  // R3
  status_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(status_rd)) |-> (rsp_data[DATA_W-1:2] == '0));
endmodule

bind gcd_mmio_periph gcd_mmio_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .engine_busy(engine_busy)
);

// File: tb/test_gcd_mmio_periph.sv
module test_gcd_mmio_periph;
  localparam int DW = 32;
  localparam int OW = 16;
  localparam int AW = 16;
  localparam logic [15:0] BASE = 16'h2000;
  localparam logic [15:0] A_STAT = BASE + 16'h0;
  localparam logic [15:0] A_OPA  = BASE + 16'h4;
  localparam logic [15:0] A_OPB  = BASE + 16'h8;
  localparam logic [15:0] A_RES  = BASE + 16'hC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, engine_busy;
  logic [DW-1:0] rsp_data;

  integer n_cmp = 0;
  integer n_bad = 0;

  always #5 clk = ~clk;

  gcd_mmio_periph #(.DATA_W(DW), .OP_W(OW), .ADDR_W(AW), .BASE_ADDR(BASE)) i_gcd_mmio_periph (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .engine_busy(engine_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int euclid(input int a, input int b);
    int t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  // behavioural reference: 0 idle, 1 running, 2 done
  int ms = 0;
  int ma = 0, mb = 0, mres = 0, mx = 0, mslot = 0;
  bit mfull = 0, mrsp_v = 0;
  logic [31:0] mrsp_d = '0;

  function automatic bit m_launch();
    return req_valid && req_write && (req_addr[15:4] == BASE[15:4]) && (req_addr[3:2] == 2'd2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; ma = 0; mb = 0; mres = 0; mx = 0; mslot = 0; mfull = 0;
      mrsp_v = 0; mrsp_d = '0;
    end else begin
      automatic bit hit = (req_addr[15:4] == BASE[15:4]);
      automatic int w = req_addr[3:2];
      automatic bit acc = req_valid && !(m_launch() && ms != 0);
      automatic bit rd = acc && !req_write;
      automatic logic [31:0] rdd = 0;
      automatic bit drain, fill;
      if (hit && w == 0) rdd = {30'd0, mfull, (ms == 0)};
      else if (hit && w == 3) rdd = mslot;
      drain = rd && hit && w == 3 && mfull;
      fill = (ms == 2) && (!mfull || drain);
      if (fill) begin mfull = 1; mslot = mres; end
      else if (drain) mfull = 0;
      if (ms == 0) begin
        if (acc && m_launch()) begin ma = mx; mb = int'(req_wdata[15:0]); ms = 1; end
      end else if (ms == 1) begin
        if (ma == 0) begin mres = mb; ms = 2; end
        else if (mb == 0) begin mres = ma; ms = 2; end
        else if (ma >= mb) ma = ma - mb;
        else mb = mb - ma;
      end else if (fill) ms = 0;
      if (acc && req_write && hit && w == 1) mx = int'(req_wdata[15:0]);
      mrsp_v = rd;
      mrsp_d = rdd;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 busy", {31'd0, engine_busy}, {31'd0, ms == 1});
      chk("R6 req_ready", {31'd0, req_ready}, {31'd0, !(m_launch() && ms != 0)});
      chk("R8 rsp_valid", {31'd0, rsp_valid}, {31'd0, mrsp_v});
      if (mrsp_v) chk("R8 rsp_data", rsp_data, mrsp_d);
    end
  end

  task automatic bus_op(input bit wr, input logic [15:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    bit acc;
    stalls = 0;
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
    do begin
      @(negedge clk); acc = req_ready;
      if (!acc) stalls++;
      @(posedge clk); #1;
    end while (!acc);
    req_valid = 0; req_write = 0;
    rd = '0;
    if (!wr) begin @(negedge clk); rd = rsp_data; end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] r; int s;
    bus_op(1, a, d, r, s);
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    int s;
    bus_op(0, a, 0, d, s);
  endtask

  task automatic wait_result();
    logic [31:0] st;
    do rd(A_STAT, st); while (st[1] == 1'b0);
  endtask

  task automatic run_gcd(input int x, input int y);
    logic [31:0] r;
    wr(A_OPA, x);
    wr(A_OPB, y);
    wait_result();
    rd(A_RES, r);
    chk("R4 result", r, euclid(x, y));
    rd(A_STAT, r);
    chk("R7 status after consume", r, 32'h1);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int s, cnt;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", {31'd0, engine_busy}, 0);
    rd(A_STAT, r); chk("R1 R3 status after reset", r, 32'h1);
    rd(A_RES, r);  chk("R1 result after reset", r, 0);

    run_gcd(48, 18);
    run_gcd(0, 7);
    run_gcd(9, 0);
    run_gcd(0, 0);
    run_gcd(13, 13);
    run_gcd(1071, 462);
    run_gcd(1, 700);
    run_gcd(65535, 255);

    // R7: no result waiting, read returns last value, slot untouched
    rd(A_RES, r); chk("R7 repeat read returns last", r, 255);
    rd(A_STAT, r); chk("R7 status unchanged", r, 32'h1);

    // R5: busy duration 12,8 -> 3 steps + 1
    wr(A_OPA, 12);
    wr(A_OPB, 8);
    cnt = 0;
    @(negedge clk);
    while (engine_busy) begin cnt++; @(negedge clk); end
    chk("R5 busy cycles 12,8", cnt, 4);
    wait_result(); rd(A_RES, r); chk("R4 12,8", r, 4);

    // R2: out-of-window launch and read have no effect
    wr(16'h3008, 5);
    repeat (3) @(negedge clk);
    chk("R2 no launch outside window", {31'd0, engine_busy}, 0);
    rd(16'h300C, r); chk("R2 outside read zero", r, 0);
    rd(A_STAT, r); chk("R2 status unchanged", r, 32'h1);

    // R8: operand regs read 0, writes to read-only offsets ignored
    rd(A_OPA, r); chk("R8 opa reads zero", r, 0);
    rd(A_OPB, r); chk("R8 opb reads zero", r, 0);
    wr(A_RES, 32'hFFFF); wr(A_STAT, 32'h3);
    rd(A_STAT, r); chk("R8 status write ignored", r, 32'h1);
    rd(A_RES, r); chk("R8 result write ignored", r, 4);

    // R6 / R9: launch during a run stalls, results come back in order
    wr(A_OPA, 2);
    wr(A_OPB, 300);
    wr(A_OPA, 9);
    bus_op(1, A_OPB, 6, r, s);
    chk("R6 launch during run stalled", {31'd0, s > 0}, 1);
    wait_result();
    rd(A_RES, r); chk("R9 first result", r, 2);
    wait_result();
    rd(A_RES, r); chk("R9 second result", r, 3);
    rd(A_STAT, r); chk("R9 slot empty", r, 32'h1);

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule